// File: doc/BRIEF.md
# Paired-Access General Register Bank

This block is the working register store of a small single-cycle processor datapath. It holds 32 byte-wide registers and offers, every clock, two independent byte read ports, a 16-bit read of an aligned register pair, a byte write port and a 16-bit pair write port. These cover the datapath's four access shapes:
- one byte read with a byte write
- two byte reads with a byte write
- two byte reads with a pair write
- a pair read with a pair write

A pair is an even register holding the low byte and the next odd register holding the high byte, selected by a 4-bit pair number.

The same registers also sit at data addresses 0 to 31, so the load/store side can reach them through an address-based byte port. Addresses from 32 upward belong to other memory and are ignored here. The three top pairs are always visible as the 16-bit address pointers P0, P1 and P2, which can in turn hold any register's data address. All reads are combinational and show the stored value. Writes land at the rising clock edge, so a read in the same cycle as a write returns the old value.

Top module: `gpr_pair_file`

## Requirements
- R1: After reset every one of the 32 registers reads as 0x00.
- R2: Byte read ports A and B each return, in the same cycle, the stored value of the register named by their 5-bit index, independently of each other.
- R3: The pair read port returns {register 2p+1, register 2p} for 4-bit pair number p (high byte in bits 15:8).
- R4: When the byte write enable is high, the addressed register takes the write data at the next rising edge.
- R5: When the pair write enable is high, bits 7:0 of the write data go to register 2p and bits 15:8 go to register 2p+1 at the next rising edge.
- R6: A read in the same cycle as a write to that register returns the old value; the new value is visible from the following cycle.
- R7: The data-space port maps address n (0 to 31) to register n. Its read data is combinational and its hit flag is high. With the write strobe high it writes the register at the next edge.
- R8: For a data-space address of 32 or more the hit flag is low, the read data is 0x00 and a write strobe changes no register.
- R9: When several writes target one register in a cycle, the pair write wins over the byte write, and either datapath write wins over the data-space write.
- R10: Pointer P0 shows {r27, r26}, P1 shows {r29, r28} and P2 shows {r31, r30}, tracking every write to those registers.
- R11: Writes from different ports to different registers in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Byte read port A register index |
| rd_a_data | output | 8 | Byte read port A data |
| rd_b_idx | input | 5 | Byte read port B register index |
| rd_b_data | output | 8 | Byte read port B data |
| rd_pair_idx | input | 4 | Pair read number |
| rd_pair_data | output | 16 | Pair read data, high register in 15:8 |
| wr8_en | input | 1 | Byte write enable |
| wr8_idx | input | 5 | Byte write register index |
| wr8_data | input | 8 | Byte write data |
| wr16_en | input | 1 | Pair write enable |
| wr16_pair | input | 4 | Pair write number |
| wr16_data | input | 16 | Pair write data |
| mem_addr | input | 16 | Data-space byte address |
| mem_we | input | 1 | Data-space write strobe |
| mem_wdata | input | 8 | Data-space write data |
| mem_rdata | output | 8 | Data-space read data (0 on miss) |
| mem_hit | output | 1 | Address falls inside the register window |
| ptr_p0 | output | 16 | Pointer pair 13 (r27:r26) |
| ptr_p1 | output | 16 | Pointer pair 14 (r29:r28) |
| ptr_p2 | output | 16 | Pointer pair 15 (r31:r30) |

## Verification
Directed cases come first. Single-port writes, followed by a full index sweep, show whether each port lands in the right register and byte lane. Same-cycle read-after-write checks whether reads see old or new data. A three-way collision on one pair separates the pair-over-byte-over-memory priority from a plain last-writer order. Out-of-window stores with the datapath idle expose any alias of high addresses onto the file. A long random phase then drives all ports at once against a behavioural model on every clock, half of the memory addresses outside the window, to reach overlap combinations the directed cases miss.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  // Which source a register takes at the next edge
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_W8   = 2'd2,
    SRC_W16  = 2'd3
  } wr_src_e;

  // Pair number that owns a register
  function automatic int unsigned pair_of(input int unsigned reg_i);
    return reg_i / 2;
  endfunction

  // Odd registers carry the high byte of their pair
  function automatic bit is_high_byte(input int unsigned reg_i);
    return (reg_i % 2) == 1;
  endfunction

  // Write priority: pair write, then byte write, then data space
  function automatic wr_src_e pick_src(input logic hit16, input logic hit8,
                                       input logic hitm);
    if (hit16)     return SRC_W16;
    else if (hit8) return SRC_W8;
    else if (hitm) return SRC_MEM;
    else           return SRC_HOLD;
  endfunction

endpackage

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG*DW-1:0] store_flat,
  input  logic [IDX_W-1:0]   idx,
  output logic [DW-1:0]      data
);
  assign data = store_flat[int'(idx)*DW +: DW];
endmodule

// File: rtl/gpr_write_arb.sv
module gpr_write_arb #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  localparam int IDX_W  = $clog2(NREG),
  localparam int PAIR_W = IDX_W - 1
) (
  input  logic                 wr8_en,
  input  logic [IDX_W-1:0]     wr8_idx,
  input  logic [DW-1:0]        wr8_data,
  input  logic                 wr16_en,
  input  logic [PAIR_W-1:0]    wr16_pair,
  input  logic [2*DW-1:0]      wr16_data,
  input  logic                 mem_wr_ok,
  input  logic [IDX_W-1:0]     mem_idx,
  input  logic [DW-1:0]        mem_wdata,
  output logic [NREG-1:0]      reg_we,
  output logic [NREG*DW-1:0]   reg_wdata,
  output logic                 mem_lost
);
  import gpr_pkg::*;

  logic [NREG-1:0] lost_vec;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic    hit16, hit8, hitm;
    logic [DW-1:0] lane16;
    wr_src_e src;

    assign hit16 = wr16_en && (wr16_pair == PAIR_W'(pair_of(i)));
    assign hit8  = wr8_en  && (wr8_idx == IDX_W'(i));
    assign hitm  = mem_wr_ok && (mem_idx == IDX_W'(i));
    assign src   = pick_src(hit16, hit8, hitm);

    if (is_high_byte(i)) begin : g_hi
      assign lane16 = wr16_data[2*DW-1:DW];
    end else begin : g_lo
      assign lane16 = wr16_data[DW-1:0];
    end

    always_comb begin
      unique case (src)
        SRC_W16: reg_wdata[i*DW +: DW] = lane16;
        SRC_W8:  reg_wdata[i*DW +: DW] = wr8_data;
        SRC_MEM: reg_wdata[i*DW +: DW] = mem_wdata;
        default: reg_wdata[i*DW +: DW] = '0;
      endcase
    end

    assign reg_we[i]   = (src != SRC_HOLD);
    assign lost_vec[i] = hitm && (src != SRC_MEM);
  end

  assign mem_lost = |lost_vec;
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int NREG = 32,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    reg_we,
  input  logic [NREG*DW-1:0] reg_wdata,
  output logic [NREG*DW-1:0] store_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        store_flat[i*DW +: DW] <= '0;
      else if (reg_we[i])
        store_flat[i*DW +: DW] <= reg_wdata[i*DW +: DW];
    end
  end
endmodule

// File: rtl/gpr_pair_file.sv
module gpr_pair_file #(
  parameter int NREG   = 32,
  parameter int DW     = 8,
  parameter int ADDR_W = 16,
  parameter int P0_PAIR = 13,
  parameter int P1_PAIR = 14,
  parameter int P2_PAIR = 15,
  localparam int IDX_W  = $clog2(NREG),
  localparam int PAIR_W = IDX_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DW-1:0]     rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DW-1:0]     rd_b_data,
  input  logic [PAIR_W-1:0] rd_pair_idx,
  output logic [2*DW-1:0]   rd_pair_data,
  input  logic              wr8_en,
  input  logic [IDX_W-1:0]  wr8_idx,
  input  logic [DW-1:0]     wr8_data,
  input  logic              wr16_en,
  input  logic [PAIR_W-1:0] wr16_pair,
  input  logic [2*DW-1:0]   wr16_data,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_we,
  input  logic [DW-1:0]     mem_wdata,
  output logic [DW-1:0]     mem_rdata,
  output logic              mem_hit,
  output logic [2*DW-1:0]   ptr_p0,
  output logic [2*DW-1:0]   ptr_p1,
  output logic [2*DW-1:0]   ptr_p2
);
  localparam int NPTR = 3;
  localparam int PTR_PAIRS [NPTR] = '{P0_PAIR, P1_PAIR, P2_PAIR};

  // Named internal events, observed by the bound checker
  logic [NREG*DW-1:0] store_flat;
  logic [NREG-1:0]    reg_we;
  logic [NREG*DW-1:0] reg_wdata;
  logic               mem_wr_ok;
  logic               mem_lost;
  logic [DW-1:0]      mem_byte;
  logic [2*DW-1:0]    ptr_bus [NPTR];

  assign mem_hit   = (mem_addr < ADDR_W'(NREG));
  assign mem_wr_ok = mem_we && mem_hit;

  gpr_write_arb #(.NREG(NREG), .DW(DW)) arb_i (
    .wr8_en    (wr8_en),
    .wr8_idx   (wr8_idx),
    .wr8_data  (wr8_data),
    .wr16_en   (wr16_en),
    .wr16_pair (wr16_pair),
    .wr16_data (wr16_data),
    .mem_wr_ok (mem_wr_ok),
    .mem_idx   (mem_addr[IDX_W-1:0]),
    .mem_wdata (mem_wdata),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .mem_lost  (mem_lost)
  );

  gpr_storage #(.NREG(NREG), .DW(DW)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .store_flat (store_flat)
  );

  gpr_read_port #(.NREG(NREG), .DW(DW)) rd_a_i (
    .store_flat (store_flat), .idx (rd_a_idx), .data (rd_a_data));

  gpr_read_port #(.NREG(NREG), .DW(DW)) rd_b_i (
    .store_flat (store_flat), .idx (rd_b_idx), .data (rd_b_data));

  gpr_read_port #(.NREG(NREG), .DW(DW)) rd_pl_i (
    .store_flat (store_flat), .idx ({rd_pair_idx, 1'b0}),
    .data (rd_pair_data[DW-1:0]));

  gpr_read_port #(.NREG(NREG), .DW(DW)) rd_ph_i (
    .store_flat (store_flat), .idx ({rd_pair_idx, 1'b1}),
    .data (rd_pair_data[2*DW-1:DW]));

  gpr_read_port #(.NREG(NREG), .DW(DW)) rd_m_i (
    .store_flat (store_flat), .idx (mem_addr[IDX_W-1:0]), .data (mem_byte));

  assign mem_rdata = mem_hit ? mem_byte : '0;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    gpr_read_port #(.NREG(NREG), .DW(DW)) lo_i (
      .store_flat (store_flat), .idx (IDX_W'(2 * PTR_PAIRS[g])),
      .data (ptr_bus[g][DW-1:0]));
    gpr_read_port #(.NREG(NREG), .DW(DW)) hi_i (
      .store_flat (store_flat), .idx (IDX_W'(2 * PTR_PAIRS[g] + 1)),
      .data (ptr_bus[g][2*DW-1:DW]));
  end

  assign ptr_p0 = ptr_bus[0];
  assign ptr_p1 = ptr_bus[1];
  assign ptr_p2 = ptr_bus[2];
endmodule

// File: rtl/gpr_pair_file_chk.sv
module gpr_pair_file_chk #(
  parameter int NREG   = 32,
  parameter int DW     = 8,
  parameter int ADDR_W = 16,
  parameter int P2_PAIR = 15,
  localparam int IDX_W  = $clog2(NREG),
  localparam int PAIR_W = IDX_W - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [IDX_W-1:0]   rd_a_idx,
  input logic [DW-1:0]      rd_a_data,
  input logic [PAIR_W-1:0]  rd_pair_idx,
  input logic [2*DW-1:0]    rd_pair_data,
  input logic               wr8_en,
  input logic [IDX_W-1:0]   wr8_idx,
  input logic               wr16_en,
  input logic [PAIR_W-1:0]  wr16_pair,
  input logic [2*DW-1:0]    wr16_data,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               mem_we,
  input logic [DW-1:0]      mem_rdata,
  input logic               mem_hit,
  input logic [2*DW-1:0]    ptr_p2,
  input logic [NREG*DW-1:0] store_flat,
  input logic               mem_lost
);

  AST_PAIR_LOW_MATCHES_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == {rd_pair_idx, 1'b0}) |-> (rd_a_data == rd_pair_data[DW-1:0])); // R3

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_hit |-> (mem_rdata == '0)); // R8

  AST_MISS_WRITES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_hit && !wr8_en && !wr16_en) |=> $stable(store_flat)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we && !wr8_en && !wr16_en) |=> $stable(store_flat)); // R4

  AST_P2_LOADS_FROM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16_en && wr16_pair == PAIR_W'(P2_PAIR)) |=> (ptr_p2 == $past(wr16_data))); // R10

  AST_BYTE_BEATS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr8_en && mem_we && mem_hit && mem_addr[IDX_W-1:0] == wr8_idx) |-> mem_lost); // R9

  AST_LOST_NEEDS_DP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lost |-> (wr8_en || wr16_en)); // R9

endmodule

bind gpr_pair_file gpr_pair_file_chk #(
  .NREG(NREG), .DW(DW), .ADDR_W(ADDR_W), .P2_PAIR(P2_PAIR)
) chk_i (.*);

// File: tb/gpr_pair_file_tb_top.sv
`timescale 1ns/1ps
module gpr_pair_file_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0;
  logic [7:0]  rd_a_data, rd_b_data;
  logic [3:0]  rd_pair_idx = '0;
  logic [15:0] rd_pair_data;
  logic        wr8_en = 1'b0;
  logic [4:0]  wr8_idx = '0;
  logic [7:0]  wr8_data = '0;
  logic        wr16_en = 1'b0;
  logic [3:0]  wr16_pair = '0;
  logic [15:0] wr16_data = '0;
  logic [15:0] mem_addr = '0;
  logic        mem_we = 1'b0;
  logic [7:0]  mem_wdata = '0;
  logic [7:0]  mem_rdata;
  logic        mem_hit;
  logic [15:0] ptr_p0, ptr_p1, ptr_p2;

  int n_tests = 0;
  int n_fail  = 0;
  byte unsigned model [32];

  always #2 clk = ~clk;  // 250 MHz

  gpr_pair_file dut_i (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mpair(input int p);
    return {model[2*p+1], model[2*p]};
  endfunction

  // Compare every output against the model (values before the coming edge)
  task automatic check_all(input string req);
    int a;
    #1;
    a = int'(mem_addr);
    chk(req, "rd_a",  rd_a_data, model[rd_a_idx]);
    chk(req, "rd_b",  rd_b_data, model[rd_b_idx]);
    chk(req, "pair",  rd_pair_data, mpair(rd_pair_idx));
    chk(req, "hit",   mem_hit, (a < 32));
    chk(req, "mrd",   mem_rdata, (a < 32) ? model[a] : 8'h00);
    chk(req, "p0",    ptr_p0, mpair(13));
    chk(req, "p1",    ptr_p1, mpair(14));
    chk(req, "p2",    ptr_p2, mpair(15));
  endtask

  // Advance one clock; model writes applied lowest priority first
  task automatic tick();
    @(posedge clk);
    if (mem_we && int'(mem_addr) < 32) model[mem_addr[4:0]] = mem_wdata;
    if (wr8_en) model[wr8_idx] = wr8_data;
    if (wr16_en) begin
      model[2*wr16_pair]   = wr16_data[7:0];
      model[2*wr16_pair+1] = wr16_data[15:8];
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wr8_en = 0; wr16_en = 0; mem_we = 0;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i);
      #1;
      chk(req, "sweep", rd_a_data, model[i]);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset clears all registers
    sweep("R1");
    check_all("R1");

    // R4, R6: byte write, same-cycle read sees old value
    wr8_en = 1; wr8_idx = 5; wr8_data = 8'hA5; rd_a_idx = 5; rd_b_idx = 5;
    #1; chk("R6", "old", rd_a_data, 8'h00);
    tick(); idle();
    #1; chk("R4", "new", rd_a_data, 8'hA5);
    chk("R6", "newb", rd_b_data, 8'hA5);

    // R5, R3: pair write lands low/high
    wr16_en = 1; wr16_pair = 3; wr16_data = 16'h1234; rd_pair_idx = 3;
    #1; chk("R6", "pair_old", rd_pair_data, 16'h0000);
    tick(); idle();
    rd_a_idx = 6; rd_b_idx = 7;
    #1;
    chk("R5", "lo", rd_a_data, 8'h34);
    chk("R5", "hi", rd_b_data, 8'h12);
    chk("R3", "pair", rd_pair_data, 16'h1234);

    // R7: data-space write and read
    mem_addr = 16'd9; mem_we = 1; mem_wdata = 8'h77;
    tick(); idle();
    rd_a_idx = 9;
    #1;
    chk("R7", "via_a", rd_a_data, 8'h77);
    chk("R7", "mrd", mem_rdata, 8'h77);
    chk("R7", "hit", mem_hit, 1'b1);

    // R8: out-of-window store ignored (addr 41 aliases reg 9 if bits dropped)
    mem_addr = 16'd41; mem_we = 1; mem_wdata = 8'hEE;
    #1; chk("R8", "hit", mem_hit, 1'b0);
    chk("R8", "mrd", mem_rdata, 8'h00);
    tick(); idle();
    mem_addr = 16'h8009; mem_we = 1; mem_wdata = 8'hDD;
    tick(); idle();
    sweep("R8");

    // R9: pair beats byte beats data space
    wr16_en = 1; wr16_pair = 2; wr16_data = 16'hBEEF;
    wr8_en = 1; wr8_idx = 4; wr8_data = 8'h11;
    mem_we = 1; mem_addr = 16'd5; mem_wdata = 8'h22;
    tick(); idle();
    rd_pair_idx = 2;
    #1; chk("R9", "pair_wins", rd_pair_data, 16'hBEEF);
    wr8_en = 1; wr8_idx = 8; wr8_data = 8'h33;
    mem_we = 1; mem_addr = 16'd8; mem_wdata = 8'h44;
    tick(); idle();
    rd_a_idx = 8;
    #1; chk("R9", "byte_wins", rd_a_data, 8'h33);

    // R10: pointer pairs
    wr16_en = 1; wr16_pair = 13; wr16_data = 16'h0102; tick();
    wr16_pair = 14; wr16_data = 16'h0304; tick();
    wr16_pair = 15; wr16_data = 16'h001F; tick(); idle();
    #1;
    chk("R10", "p0", ptr_p0, 16'h0102);
    chk("R10", "p1", ptr_p1, 16'h0304);
    chk("R10", "p2", ptr_p2, 16'h001F);
    wr8_en = 1; wr8_idx = 31; wr8_data = 8'hC0; tick(); idle();
    #1; chk("R10", "p2_byte", ptr_p2, 16'hC01F);

    // R11: three writes to distinct registers in one cycle
    wr16_en = 1; wr16_pair = 0; wr16_data = 16'hA1A0;
    wr8_en = 1; wr8_idx = 20; wr8_data = 8'h5A;
    mem_we = 1; mem_addr = 16'd25; mem_wdata = 8'h6B;
    tick(); idle();
    sweep("R11");

    // R2, R7, R9: random traffic on all ports against the model
    for (int c = 0; c < 3000; c++) begin
      rd_a_idx    = 5'($urandom_range(31));
      rd_b_idx    = 5'($urandom_range(31));
      rd_pair_idx = 4'($urandom_range(15));
      wr8_en      = 1'($urandom_range(1));
      wr8_idx     = 5'($urandom_range(31));
      wr8_data    = 8'($urandom);
      wr16_en     = 1'($urandom_range(1));
      wr16_pair   = 4'($urandom_range(15));
      wr16_data   = 16'($urandom);
      mem_we      = 1'($urandom_range(1));
      mem_addr    = 16'($urandom_range(63));
      mem_wdata   = 8'($urandom);
      check_all("R2");
      tick();
    end
    idle();
    check_all("R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule